// File: doc/BRIEF.md
# DMA Channel Trigger Latch

This block is the trigger front end of one DMA channel. A select field picks one of a bank of peripheral event lines. A rising edge on the selected line, or a software force pulse, is latched into a pending flag. While that flag is set, and the channel's interrupt enable and run status are both on, the block raises a service request toward the channel arbiter. The arbiter reports the start of this channel's burst, and that report clears the flag.

Every accepted peripheral event sends a single-cycle acknowledge pulse back to the source that caused it, so the source can raise its next event. If a further trigger arrives while one is still waiting, a sticky overflow flag is set. Software can also drop a waiting trigger with a clear pulse, and can reset the overflow flag with a pulse of its own. A controller with several channels uses one copy of this block for each channel.

Top module: `dma_trig_latch`

## Requirements
- R1: After reset, pend_o, ovf_o, req_o and every bit of src_ack_o are 0.
- R2: A rising edge on src_evt_i[k], with src_sel_i equal to k and 1 <= k < NUM_SRC (29), sets pend_o on the next clock. Select value 0, select values of NUM_SRC or more, and edges on lines that are not selected do not set pend_o.
- R3: A selected line held high over several cycles counts as one event. Only its 0-to-1 transition sets the flag.
- R4: sw_force_i sets pend_o on the next clock, whatever the select value is.
- R5: When no trigger is present in a cycle, burst_start_i or sw_clr_i in that cycle clears pend_o on the next clock.
- R6: A trigger in the same cycle as burst_start_i or sw_clr_i wins, and pend_o stays 1.
- R7: req_o equals pend_o AND int_en_i AND run_i AND NOT burst_active_i, with no delay. A trigger that arrives during a burst therefore waits until the burst ends.
- R8: A trigger in a cycle where pend_o is already 1 and no clear is present sets ovf_o on the next clock. ovf_o stays 1 until an ovf_clr_i pulse, and a new overflow in the same cycle as that pulse wins.
- R9: One clock after an accepted peripheral event with select value k, src_ack_o has only bit k set, and it is set for that one cycle only. A force pulse produces no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_evt_i | input | NUM_SRC | Peripheral event lines (bit 0 unused) |
| src_sel_i | input | SEL_W | Trigger source select, 0 = none |
| sw_force_i | input | 1 | Software force pulse |
| sw_clr_i | input | 1 | Software pending-clear pulse |
| ovf_clr_i | input | 1 | Software overflow-clear pulse |
| int_en_i | input | 1 | Channel interrupt enable |
| run_i | input | 1 | Channel run status |
| burst_start_i | input | 1 | Arbiter has started this channel's burst |
| burst_active_i | input | 1 | A burst of this channel is in progress |
| req_o | output | 1 | Service request to the arbiter |
| pend_o | output | 1 | Pending trigger flag |
| ovf_o | output | 1 | Sticky trigger overflow flag |
| src_ack_o | output | NUM_SRC | One-hot acknowledge-clear pulse to the sources |

## Verification
A wrong pending state appears on pend_o one clock after the input that caused it. It reaches req_o in the same cycle whenever the channel is enabled and running. A bad edge history in the detector shows up as a missed event or a repeated event on a held line. That error appears on pend_o and on the acknowledge vector one clock later, and on ovf_o when a second trigger follows. A wrong decode appears as an acknowledge on the wrong bit, or on more than one bit, in the cycle after the event. An overflow flag that was lost or set in error stays visible until the next overflow-clear pulse.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

   // Trigger causes seen by the pending latch in one cycle.
   typedef struct packed {
      logic periph;   // accepted edge on the selected source
      logic force_sw; // software force
   } trig_cause_t;

   // Clear causes seen by the pending latch in one cycle.
   typedef struct packed {
      logic burst;    // arbiter started the burst
      logic sw;       // software clear
   } trig_clear_t;

endpackage

// File: rtl/trg_edge_det.sv
module trg_edge_det #(
   parameter int unsigned WIDTH = 29
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;

   // R3
   held_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lvl_i[WIDTH-1] |=> !rise_o[WIDTH-1]);

endmodule

// File: rtl/trg_src_sel.sv
module trg_src_sel #(
   parameter int unsigned NUM_SRC = 29,
   parameter int unsigned SEL_W   = 5
) (
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [NUM_SRC-1:0] rise_i,
   output logic [NUM_SRC-1:0] dec_o,
   output logic               hit_o
);

   // Index 0 means no source. Values of NUM_SRC or more decode to nothing.
   assign dec_o[0] = 1'b0;

   for (genvar k = 1; k < NUM_SRC; k++) begin : g_dec
      assign dec_o[k] = (sel_i == SEL_W'(k));
   end

   assign hit_o = |(dec_o & rise_i);

   // R2
   dec_onehot_chk: assert final ($onehot0(dec_o));

endmodule

// File: rtl/trg_pend_ctl.sv
module trg_pend_ctl
   import dma_trig_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  trig_cause_t cause_i,
   input  trig_clear_t clear_i,
   input  logic        ovf_clr_i,
   output logic        pend_o,
   output logic        ovf_o
);

   logic trig;
   logic clr;
   logic pend_d;
   logic ovf_d;

   assign trig = cause_i.periph | cause_i.force_sw;
   assign clr  = clear_i.burst | clear_i.sw;

   always_comb begin
      pend_d = pend_o;
      if (trig)     pend_d = 1'b1;
      else if (clr) pend_d = 1'b0;
   end

   always_comb begin
      ovf_d = ovf_o;
      if (ovf_clr_i)                ovf_d = 1'b0;
      if (trig && pend_o && !clr)   ovf_d = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_o <= 1'b0;
         ovf_o  <= 1'b0;
      end else begin
         pend_o <= pend_d;
         ovf_o  <= ovf_d;
      end
   end

   // R6
   trig_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cause_i.periph || cause_i.force_sw) |=> pend_o);

   // R5
   clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clear_i.burst || clear_i.sw) && !cause_i.periph && !cause_i.force_sw) |=> !pend_o);

   // R8
   ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cause_i.periph || cause_i.force_sw) && pend_o && !clear_i.burst && !clear_i.sw) |=> ovf_o);

   // R8
   ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o && !ovf_clr_i) |=> ovf_o);

endmodule

// File: rtl/dma_trig_latch.sv
module dma_trig_latch
   import dma_trig_pkg::*;
#(
   parameter int unsigned NUM_SRC = 29,
   parameter int unsigned SEL_W   = 5,
   parameter bit          ACK_REG = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_evt_i,
   input  logic [SEL_W-1:0]   src_sel_i,
   input  logic               sw_force_i,
   input  logic               sw_clr_i,
   input  logic               ovf_clr_i,
   input  logic               int_en_i,
   input  logic               run_i,
   input  logic               burst_start_i,
   input  logic               burst_active_i,
   output logic               req_o,
   output logic               pend_o,
   output logic               ovf_o,
   output logic [NUM_SRC-1:0] src_ack_o
);

   localparam int unsigned MIN_SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 2) begin : g_bad_num
      $error("dma_trig_latch: NUM_SRC must be at least 2");
   end
   if (SEL_W < MIN_SEL_W) begin : g_bad_sel
      $error("dma_trig_latch: SEL_W too narrow for NUM_SRC");
   end

   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] dec;
   logic               periph_hit;
   trig_cause_t        cause;
   trig_clear_t        clear;

   trg_edge_det #(.WIDTH(NUM_SRC)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (src_evt_i),
      .rise_o (rise)
   );

   trg_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
      .sel_i  (src_sel_i),
      .rise_i (rise),
      .dec_o  (dec),
      .hit_o  (periph_hit)
   );

   assign cause.periph   = periph_hit;
   assign cause.force_sw = sw_force_i;
   assign clear.burst    = burst_start_i;
   assign clear.sw       = sw_clr_i;

   trg_pend_ctl u_pend (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cause_i   (cause),
      .clear_i   (clear),
      .ovf_clr_i (ovf_clr_i),
      .pend_o    (pend_o),
      .ovf_o     (ovf_o)
   );

   assign req_o = pend_o & int_en_i & run_i & ~burst_active_i;

   if (ACK_REG) begin : g_ack_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)         src_ack_o <= '0;
         else if (periph_hit) src_ack_o <= dec;
         else                 src_ack_o <= '0;
      end

      // R9
      ack_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (|src_ack_o) |-> pend_o);
      // R9
      ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (|src_ack_o) |=> (src_ack_o == '0) || !$stable(src_ack_o) || $past(periph_hit));
   end else begin : g_ack_comb
      assign src_ack_o = periph_hit ? dec : '0;
   end

   // R9
   ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(src_ack_o));

   // R7
   no_req_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      burst_active_i |-> !req_o);

endmodule

// File: tb/dma_trig_latch_tb_top.sv
`timescale 1ns/1ps
module dma_trig_latch_tb_top;

   localparam int unsigned NS = 29;
   localparam int unsigned SW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic [SW-1:0] sel = '0;
   logic          frc = 0, sclr = 0, oclr = 0, en = 0, run = 0, bst = 0, busy = 0;
   logic          req, pend, ovf;
   logic [NS-1:0] ack;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model state
   logic [NS-1:0] m_prev = '0;
   logic          m_pend = 0, m_ovf = 0;
   logic [NS-1:0] m_ack = '0;
   string         pend_tag = "R1";

   always #2.5 clk = ~clk;

   dma_trig_latch #(.NUM_SRC(NS), .SEL_W(SW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_evt_i(src), .src_sel_i(sel),
      .sw_force_i(frc), .sw_clr_i(sclr), .ovf_clr_i(oclr), .int_en_i(en),
      .run_i(run), .burst_start_i(bst), .burst_active_i(busy),
      .req_o(req), .pend_o(pend), .ovf_o(ovf), .src_ack_o(ack)
   );

   task automatic check(input string tag, input string what,
                        input logic [NS-1:0] act, input logic [NS-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic sel_hit(input logic [SW-1:0] s, input logic [NS-1:0] r);
      return (s >= 1) && (s < NS) && r[s];
   endfunction

   // Called with inputs already driven after a falling edge.
   task automatic cyc();
      logic [NS-1:0] r;
      logic hit, trig, clr;
      #1;
      check("R7", "req", NS'(req), NS'(m_pend & en & run & ~busy));
      r    = src & ~m_prev;
      hit  = sel_hit(sel, r);
      trig = hit | frc;
      clr  = bst | sclr;
      if (trig && clr)  pend_tag = "R6";
      else if (frc)     pend_tag = "R4";
      else if (hit)     pend_tag = "R2";
      else if (clr)     pend_tag = "R5";
      else              pend_tag = "R2";
      if (oclr) m_ovf = 0;
      if (trig && m_pend && !clr) m_ovf = 1;
      if (trig) m_pend = 1; else if (clr) m_pend = 0;
      m_ack  = hit ? (NS'(1) << sel) : '0;
      m_prev = src;
      @(negedge clk);
      check(pend_tag, "pend", NS'(pend), NS'(m_pend));
      check("R8", "ovf", NS'(ovf), NS'(m_ovf));
      check("R9", "ack", ack, m_ack);
   endtask

   task automatic idle();
      src = '0; frc = 0; sclr = 0; oclr = 0; bst = 0; busy = 0;
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "pend", NS'(pend), '0);
      check("R1", "ovf", NS'(ovf), '0);
      check("R1", "req", NS'(req), '0);
      check("R1", "ack", ack, '0);
      rst_n = 1'b1;
      @(negedge clk);
      en = 1; run = 1;

      // R2: selected edge, then clear via burst start
      sel = 5'd5; src[5] = 1; cyc();
      idle(); bst = 1; cyc();
      // R2: unselected line and select 0 / 30 ignored
      idle(); src[6] = 1; cyc();
      idle(); sel = 5'd0; src[0] = 1; cyc();
      idle(); sel = 5'd30; src = '1; cyc();
      idle(); cyc();
      // R3: level held high counts once
      sel = 5'd28; src[28] = 1; cyc();
      bst = 1; cyc(); bst = 0; cyc(); cyc(); cyc();
      idle(); cyc();
      // R4: force with select 0
      sel = 5'd0; frc = 1; cyc();
      // R6: trigger with simultaneous clear
      idle(); frc = 1; sclr = 1; cyc();
      // R8: overflow, then clear colliding with new overflow
      idle(); sel = 5'd1; src[1] = 1; cyc();
      idle(); oclr = 1; frc = 1; cyc();
      idle(); oclr = 1; cyc();
      // R7: pending held during burst
      idle(); busy = 1; cyc(); busy = 0; cyc();
      idle(); sclr = 1; cyc();

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         sel  = SW'($urandom_range(0, 31));
         if ($urandom_range(0, 3) == 0) sel = SW'($urandom_range(1, 3));
         src  = NS'($urandom & $urandom & $urandom);
         frc  = ($urandom_range(0, 15) == 0);
         sclr = ($urandom_range(0, 11) == 0);
         oclr = ($urandom_range(0, 19) == 0);
         bst  = ($urandom_range(0, 5) == 0);
         busy = ($urandom_range(0, 3) == 0);
         en   = ($urandom_range(0, 7) != 0);
         run  = ($urandom_range(0, 7) != 0);
         cyc();
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule